// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block generates all of the refresh traffic for an asynchronous DRAM and runs its start-up routine. After reset it waits a programmable pause. It then asks the access controller for the strobes and issues eight wake-up refresh cycles. When those are done it raises a ready flag. From then on, an interval timer adds one owed refresh every interval. The block requests the strobes whenever any refresh is owed.

Every refresh is a CAS-before-RAS cycle. The DRAM takes the row from its own internal counter, so the block drives no address. The write strobe stays high throughout, so a refresh can never be mistaken for test-mode entry. Refreshes that the controller cannot grant at once are counted, up to a limit. If one more interval expires while the count is at that limit, the retention deadline is taken as missed. The block then drops ready, raises an overdue flag and repeats the eight-cycle wake-up. Address multiplexing and data movement are left to the access controller.

The state machine has seven states:

- `S_PAUSE`: the power-up wait.
- `S_IDLE`: nothing owed.
- `S_REQ`: request raised, waiting for the grant.
- `S_CAS_LEAD`: CAS low, RAS high.
- `S_RAS_CAS`: both strobes low.
- `S_RAS_ONLY`: RAS low, CAS released.
- `S_PRECHG`: both strobes high.

The transitions are:

- `S_PAUSE` to `S_REQ` when the pause ends.
- `S_IDLE` to `S_REQ` when not ready or when a refresh is owed.
- `S_REQ` to `S_CAS_LEAD` on grant.
- `S_CAS_LEAD` to `S_RAS_CAS` after the CAS setup time.
- `S_RAS_CAS` to `S_RAS_ONLY` after the CAS hold time.
- `S_RAS_ONLY` to `S_PRECHG` when the RAS low time ends.
- `S_PRECHG` to `S_IDLE` when precharge ends. This edge completes one refresh cycle.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, and on its release, `ras_n`, `cas_n` and `we_n` are high (1 = inactive), and `rfsh_req`, `init_done` and `rfsh_overdue` are low.
- R2: After reset is released, `rfsh_req` stays low until the PAUSE_CYC-th rising clock edge. It is high after that edge.
- R3: While `rfsh_req` is high and `rfsh_gnt` is low, both strobes stay high.
- R4: In every refresh cycle, `cas_n` falls CSR_CYC cycles before `ras_n` falls. Both stay low together for CHR_CYC cycles. `ras_n` stays low for RAS_CYC cycles in total, and `cas_n` rises before `ras_n`. `ras_n` never falls while `cas_n` is high.
- R5: `we_n` is high in every cycle, including the cycle in which `ras_n` falls.
- R6: After `ras_n` rises, both strobes are held high for PRE_CYC cycles of precharge. Between two back-to-back cycles the strobes stay high for PRE_CYC+2 cycles in total, and `rfsh_req` rises only while both strobes are high.
- R7: The wake-up sequence is exactly WAKE_CNT (default 8) refresh cycles. `init_done` rises on the edge that ends the last precharge, and `rfsh_req` is low in that same cycle.
- R8: Once `init_done` is high, the first interval request appears INTERVAL_CYC+1 cycles after `init_done` is first seen high.
- R9: Ungranted refreshes accumulate up to MAX_PEND. When the grant arrives, exactly that many cycles are issued back to back, and `init_done` stays high.
- R10: If the interval expires while MAX_PEND refreshes are already owed, `rfsh_overdue` rises and `init_done` falls in the same cycle. A further WAKE_CNT refresh cycles then run. After them `init_done` rises again and `rfsh_overdue` clears.
- R11: While `init_done` is low, the interval timer adds no owed refreshes. When ready returns, the timer restarts from zero, so the next request again comes INTERVAL_CYC+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfsh_gnt | input | 1 | Access controller hands the strobes to this block |
| rfsh_req | output | 1 | Request for the strobes; high through the whole refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Wake-up sequence complete; DRAM usable |
| rfsh_overdue | output | 1 | Retention deadline missed; wake-up re-running |

## Verification
The assertions assume that the access controller, once it has granted, keeps `rfsh_gnt` high for as long as `rfsh_req` stays high. They also assume it never withdraws the grant in the middle of a cycle. The bench models the grant as an enable ANDed with `rfsh_req`. It changes that enable only while `rfsh_req` is low, so a grant is never pulled away mid-cycle. Starvation is produced by leaving the enable low across several intervals, which lets the owed count reach and then pass its limit.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        S_PAUSE    = 3'd0,
        S_IDLE     = 3'd1,
        S_REQ      = 3'd2,
        S_CAS_LEAD = 3'd3,
        S_RAS_CAS  = 3'd4,
        S_RAS_ONLY = 3'd5,
        S_PRECHG   = 3'd6
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
// Free-running interval counter; restarts from zero whenever disabled.
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam logic [IW-1:0] LAST = IW'(INTERVAL_CYC - 1);

    logic [IW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || (cnt == LAST)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_pend_ctr.sv
`timescale 1ns/1ps
// Count of owed refreshes. An increment that finds the count already at
// its limit (with no decrement in the same cycle) is reported as a
// saturation event and empties the count.
module rfsh_pend_ctr #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic sat_evt
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

    logic [PW-1:0] cnt;
    logic          do_dec;

    assign do_dec  = dec && (cnt != '0);
    assign sat_evt = inc && !do_dec && (cnt == LIMIT);
    assign nonzero = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sat_evt) begin
            cnt <= '0;
        end else if (inc && !do_dec) begin
            cnt <= cnt + 1'b1;
        end else if (do_dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_phase_timer.sv
`timescale 1ns/1ps
// Down counter that times each strobe phase. Loaded with length-1 when a
// phase begins; zero marks the last cycle of the phase.
module rfsh_phase_timer #(
    parameter int PH_W    = 8,
    parameter int RST_VAL = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PH_W-1:0] load_val,
    output logic            zero
);
    logic [PH_W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= PH_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int INTERVAL_CYC = 3120,   // 15.6 us at 200 MHz
    parameter int PAUSE_CYC    = 20000,  // 100 us at 200 MHz
    parameter int CSR_CYC      = 2,      // CAS low before RAS falls
    parameter int CHR_CYC      = 3,      // CAS low after RAS falls
    parameter int RAS_CYC      = 16,     // total RAS low time, > CHR_CYC
    parameter int PRE_CYC      = 12,     // RAS precharge
    parameter int WAKE_CNT     = 8,
    parameter int MAX_PEND     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic rfsh_overdue
);
    localparam int PH_W = $clog2(PAUSE_CYC + RAS_CYC + PRE_CYC + CSR_CYC + 1);
    localparam int WK_W = $clog2(WAKE_CNT + 1);
    localparam logic [WK_W-1:0] WAKE_LAST = WK_W'(WAKE_CNT - 1);

    rfsh_state_e     state, nxt;
    logic            ph_zero;
    logic            ph_load;
    logic [PH_W-1:0] ph_val;
    logic            tick;
    logic            pend_nz;
    logic            sat_evt;
    logic            cyc_done;
    logic [WK_W-1:0] wake_cnt;

    // ---------------- sub-blocks ----------------
    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (tick)
    );

    rfsh_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (cyc_done && init_done),
        .nonzero (pend_nz),
        .sat_evt (sat_evt)
    );

    rfsh_phase_timer #(.PH_W(PH_W), .RST_VAL(PAUSE_CYC - 1)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    assign cyc_done = (state == S_PRECHG) && ph_zero;

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_PAUSE:    if (ph_zero) nxt = S_REQ;
            S_IDLE:     if (!init_done || pend_nz) nxt = S_REQ;
            S_REQ:      if (rfsh_gnt) nxt = S_CAS_LEAD;
            S_CAS_LEAD: if (ph_zero) nxt = S_RAS_CAS;
            S_RAS_CAS:  if (ph_zero) nxt = S_RAS_ONLY;
            S_RAS_ONLY: if (ph_zero) nxt = S_PRECHG;
            S_PRECHG:   if (ph_zero) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // phase length for the state being entered
    always_comb begin
        ph_load = (nxt != state);
        unique case (nxt)
            S_CAS_LEAD: ph_val = PH_W'(CSR_CYC - 1);
            S_RAS_CAS:  ph_val = PH_W'(CHR_CYC - 1);
            S_RAS_ONLY: ph_val = PH_W'(RAS_CYC - CHR_CYC - 1);
            S_PRECHG:   ph_val = PH_W'(PRE_CYC - 1);
            S_PAUSE:    ph_val = PH_W'(PAUSE_CYC - 1);
            default:    ph_val = '0;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_PAUSE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- registered strobe outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_n    <= 1'b1;
            cas_n    <= 1'b1;
            we_n     <= 1'b1;
            rfsh_req <= 1'b0;
        end else begin
            ras_n    <= !(nxt inside {S_RAS_CAS, S_RAS_ONLY});
            cas_n    <= !(nxt inside {S_CAS_LEAD, S_RAS_CAS});
            we_n     <= 1'b1;  // refresh never enters test mode
            rfsh_req <= (nxt inside {S_REQ, S_CAS_LEAD, S_RAS_CAS,
                                     S_RAS_ONLY, S_PRECHG});
        end
    end

    // ---------------- wake-up and deadline tracking ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_done    <= 1'b0;
            rfsh_overdue <= 1'b0;
            wake_cnt     <= '0;
        end else if (sat_evt) begin
            init_done    <= 1'b0;
            rfsh_overdue <= 1'b1;
            wake_cnt     <= '0;
        end else if (cyc_done && !init_done) begin
            if (wake_cnt == WAKE_LAST) begin
                init_done    <= 1'b1;
                rfsh_overdue <= 1'b0;
                wake_cnt     <= '0;
            end else begin
                wake_cnt <= wake_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
`timescale 1ns/1ps
module dram_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rfsh_gnt,
    input logic rfsh_req,
    input logic ras_n,
    input logic cas_n,
    input logic init_done,
    input logic rfsh_overdue
);
    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_cas_released_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    assert_strobes_need_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> (rfsh_req && rfsh_gnt));

    assert_req_from_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfsh_req) |-> (ras_n && cas_n));

    assert_ready_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ras_n && cas_n && !rfsh_req && !rfsh_overdue));

    assert_ready_loss_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> rfsh_overdue);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rfsh_gnt     (rfsh_gnt),
    .rfsh_req     (rfsh_req),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .init_done    (init_done),
    .rfsh_overdue (rfsh_overdue)
);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
    localparam int INTERVAL = 60;
    localparam int PAUSE    = 20;
    localparam int CSR      = 2;
    localparam int CHR      = 3;
    localparam int RASL     = 6;
    localparam int PRE      = 4;
    localparam int WAKE     = 8;
    localparam int MAXP     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic allow = 1'b0;
    logic rfsh_gnt, rfsh_req, ras_n, cas_n, we_n, init_done, rfsh_overdue;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // arbiter model: grant follows request when allowed
    assign rfsh_gnt = allow & rfsh_req;

    dram_refresh_seq #(
        .INTERVAL_CYC(INTERVAL), .PAUSE_CYC(PAUSE), .CSR_CYC(CSR),
        .CHR_CYC(CHR), .RAS_CYC(RASL), .PRE_CYC(PRE),
        .WAKE_CNT(WAKE), .MAX_PEND(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
        .rfsh_overdue(rfsh_overdue)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one refresh cycle measured at negedge samples
    task automatic measure(output int lead, output int ovl, output int rlow,
                           output int we_low);
        lead = 0; ovl = 0; rlow = 0; we_low = 0;
        while (cas_n) @(negedge clk);
        while (!cas_n && ras_n) begin
            lead++; if (!we_n) we_low++; @(negedge clk);
        end
        while (!cas_n && !ras_n) begin
            ovl++; rlow++; if (!we_n) we_low++; @(negedge clk);
        end
        while (cas_n && !ras_n) begin
            rlow++; if (!we_n) we_low++; @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 we_n", we_n, 1);
        chk("R1 req", rfsh_req, 0);
        chk("R1 init_done", init_done, 0);
        chk("R1 overdue", rfsh_overdue, 0);
    endtask

    task automatic t_pause();
        int n;
        rst_n = 1'b1;
        n = 0;
        @(negedge clk);
        while (!rfsh_req && n < 10 * PAUSE) begin n++; @(negedge clk); end
        chk("R2 pause samples", n, PAUSE - 1);
    endtask

    task automatic t_no_grant();
        int bad;
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            if (!ras_n || !cas_n || !rfsh_req) bad++;
            @(negedge clk);
        end
        chk("R3 strobes idle without grant", bad, 0);
    endtask

    task automatic t_wakeup();
        int lead, ovl, rlow, wl, gap;
        allow = 1'b1;
        for (int c = 0; c < WAKE; c++) begin
            measure(lead, ovl, rlow, wl);
            if (c == 0 || c == WAKE - 1) begin
                chk("R4 cas lead", lead, CSR);
                chk("R4 cas hold", ovl, CHR);
                chk("R4 ras low", rlow, RASL);
                chk("R5 we low samples", wl, 0);
            end
            gap = 0;
            if (c < WAKE - 1) begin
                while (ras_n && cas_n && gap < 100) begin gap++; @(negedge clk); end
                chk("R6 gap between cycles", gap, PRE + 2);
                chk("R7 not ready mid wake", init_done, 0);
            end else begin
                while (!init_done && ras_n && cas_n && gap < 100) begin
                    gap++; @(negedge clk);
                end
                chk("R6 final precharge", gap, PRE);
                chk("R7 ready after eighth", init_done, 1);
                chk("R7 req low at ready", rfsh_req, 0);
            end
        end
    endtask

    task automatic t_interval(input string tag);
        int n, busy;
        n = 0; busy = 0;
        allow = 1'b0;  // req is low here
        while (!rfsh_req && n < 4 * INTERVAL) begin
            if (!ras_n || !cas_n) busy++;
            n++; @(negedge clk);
        end
        chk({tag, " first request latency"}, n, INTERVAL + 1);
        chk({tag, " quiet before request"}, busy, 0);
    endtask

    task automatic t_postponed();
        int falls, prev;
        repeat (2 * INTERVAL) @(negedge clk);
        chk("R9 strobes idle while owed", (!ras_n || !cas_n) ? 1 : 0, 0);
        allow = 1'b1;
        falls = 0; prev = ras_n;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (prev == 1 && ras_n == 0) falls++;
            prev = ras_n;
        end
        chk("R9 back-to-back count", falls, MAXP);
        chk("R9 still ready", init_done, 1);
        chk("R9 not overdue", rfsh_overdue, 0);
    endtask

    task automatic t_overdue();
        int n, falls, prev;
        allow = 1'b0;  // req is low here
        n = 0;
        while (!rfsh_overdue && n < (MAXP + 3) * INTERVAL) begin n++; @(negedge clk); end
        chk("R10 overdue raised", rfsh_overdue, 1);
        chk("R10 ready dropped", init_done, 0);
        allow = 1'b1;
        falls = 0; prev = ras_n; n = 0;
        while (!init_done && n < 1000) begin
            @(negedge clk); n++;
            if (prev == 1 && ras_n == 0) falls++;
            prev = ras_n;
        end
        chk("R10 rerun wake count", falls, WAKE);
        chk("R10 ready again", init_done, 1);
        chk("R10 overdue cleared", rfsh_overdue, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pause();
        t_no_grant();
        t_wakeup();
        t_interval("R8");
        t_postponed();
        t_overdue();
        t_interval("R11");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule